// File: doc/BRIEF.md
# Serial Link Keepalive Monitor

This block keeps a point-to-point serial link alive and notices when the far end has gone quiet. On the transmit side, a free-running interval counter asks the outbound framer to slip a keepalive code into the stream once per interval. If the framer is busy, the request waits and is issued on the framer's first idle cycle.

On the receive side, a watchdog is restarted each time the inbound decoder reports a keepalive code. If the watchdog runs out while the link is up, the block clears the link flag and emits a one-cycle link-lost event. That event starts re-initialization, which is the same sequence used at startup. The transmit interval restarts at that point, and the link comes back on the next code received.

The block does not serialize or encode the codes and does not negotiate lane width. It only times the codes and owns the link flag.

Top module: `link_keepalive_mon`

## Requirements
- R1: While rst_ni is low, code_req_o, link_up_o and link_lost_o are all 0. After reset the link stays down until a code is detected.
- R2: While en_i is high and framer_busy_i is low, code_req_o pulses once every TX_INTERVAL (default 2048) cycles. The first pulse appears in the cycle that follows the TX_INTERVAL-th clock edge at which en_i is sampled high.
- R3: code_req_o is high for one cycle at most, and it is never high while framer_busy_i is high. A request held off by busy is issued combinationally in the first cycle busy is low. Interval expiries that occur while a request is pending merge into that single request.
- R4: A code_det_i sampled high with en_i high sets link_up_o from the next cycle.
- R5: Each detected code restarts the receive watchdog at its full count. The link stays up as long as consecutive codes are at most RX_TIMEOUT (default 4096) clock edges apart, including a gap of exactly RX_TIMEOUT.
- R6: If RX_TIMEOUT consecutive clock edges pass with no code while the link is up, link_up_o falls. In that same cycle link_lost_o is high, for exactly one cycle.
- R7: A loss restarts the transmit interval, so the next code_req_o comes TX_INTERVAL cycles after the link_lost_o cycle. The link comes back up on the next detected code, with no other action needed.
- R8: Driving en_i low clears link_up_o on the next edge, without a link_lost_o pulse. It also stops requests, and code_det_i is ignored while en_i is low. Raising en_i again restarts the interval as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Block enable |
| code_det_i | input | 1 | Inbound decoder found a keepalive code (one-cycle strobe) |
| framer_busy_i | input | 1 | Outbound framer cannot take a code insertion this cycle |
| code_req_o | output | 1 | Request to insert one keepalive code (one-cycle pulse) |
| link_up_o | output | 1 | Link flag, 1 while the link is established |
| link_lost_o | output | 1 | One-cycle event when the link times out; starts re-initialization |

## Verification
The timing of each output is fixed:

- link_up_o and link_lost_o are registered, so they change one edge after the stimulus that causes them. A code sampled at edge E shows up on link_up_o after E. A silence that began after E ends the link after edge E+RX_TIMEOUT.
- code_req_o is combinational from a registered pending flag. It appears after the TX_INTERVAL-th enabled edge, or in the same cycle that framer_busy_i drops.

The bench drives inputs on falling edges and samples outputs at the next falling edge, counting the rising edges in between. For the busy release it samples a moment after the input change, because that output responds combinationally. The gap table places each code a known number of edges after the previous one, so the edges where the watchdog can and cannot expire are hit exactly.

// File: rtl/kam_pkg.sv
package kam_pkg;
  typedef enum logic {
    LINK_DOWN = 1'b0,
    LINK_UP   = 1'b1
  } link_st_e;
endpackage

// File: rtl/kam_tx_timer.sv
module kam_tx_timer #(
  parameter int unsigned TX_INTERVAL = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic restart_i,
  input  logic busy_i,
  output logic req_o
);
  localparam int unsigned CW = (TX_INTERVAL > 2) ? $clog2(TX_INTERVAL) : 1;
  localparam logic [CW-1:0] LAST = CW'(TX_INTERVAL - 1);

  logic [CW-1:0] cnt_q;
  logic          pend_q;
  logic          wrap;
  logic          fire;

  assign wrap  = (cnt_q == LAST);
  assign fire  = pend_q & ~busy_i;
  assign req_o = fire;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (!en_i || restart_i) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= wrap ? '0 : cnt_q + 1'b1;
      // an expiry coinciding with an issued request is absorbed by it
      pend_q <= (pend_q & busy_i) | (wrap & ~fire);
    end
  end
endmodule

// File: rtl/kam_rx_watchdog.sv
module kam_rx_watchdog
  import kam_pkg::*;
#(
  parameter int unsigned RX_TIMEOUT = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic code_det_i,
  output logic expire_o,
  output logic link_up_o,
  output logic link_lost_o
);
  localparam int unsigned CW = (RX_TIMEOUT > 2) ? $clog2(RX_TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(RX_TIMEOUT - 1);

  link_st_e      st_q;
  logic [CW-1:0] idle_q;
  logic          lost_q;

  assign expire_o    = en_i & ~code_det_i & (st_q == LINK_UP) & (idle_q == LAST);
  assign link_up_o   = (st_q == LINK_UP);
  assign link_lost_o = lost_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= LINK_DOWN;
      idle_q <= '0;
      lost_q <= 1'b0;
    end else begin
      lost_q <= expire_o;
      if (!en_i) begin
        st_q   <= LINK_DOWN;
        idle_q <= '0;
      end else if (code_det_i) begin
        st_q   <= LINK_UP;
        idle_q <= '0;
      end else if (st_q == LINK_UP) begin
        if (idle_q == LAST) begin
          st_q   <= LINK_DOWN;
          idle_q <= '0;
        end else begin
          idle_q <= idle_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/link_keepalive_mon.sv
module link_keepalive_mon #(
  parameter int unsigned TX_INTERVAL = 2048,
  parameter int unsigned RX_TIMEOUT  = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic code_det_i,
  input  logic framer_busy_i,
  output logic code_req_o,
  output logic link_up_o,
  output logic link_lost_o
);
  logic expire;

  kam_rx_watchdog #(
    .RX_TIMEOUT(RX_TIMEOUT)
  ) i_rx_wd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .code_det_i  (code_det_i),
    .expire_o    (expire),
    .link_up_o   (link_up_o),
    .link_lost_o (link_lost_o)
  );

  // loss restarts the transmit side exactly as startup does
  kam_tx_timer #(
    .TX_INTERVAL(TX_INTERVAL)
  ) i_tx_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .restart_i (expire),
    .busy_i    (framer_busy_i),
    .req_o     (code_req_o)
  );
endmodule

// File: rtl/kam_checker.sv
module kam_checker #(
  parameter int unsigned RX_TIMEOUT = 4096
) (
  input logic clk_i,
  input logic rst_ni,
  input logic en_i,
  input logic code_det_i,
  input logic framer_busy_i,
  input logic code_req_o,
  input logic link_up_o,
  input logic link_lost_o
);
  localparam int unsigned GW = $clog2(RX_TIMEOUT) + 2;

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  gap_q <= '0;
    else if (!en_i || code_det_i) gap_q <= '0;
    else if (link_up_o)           gap_q <= gap_q + 1'b1;
    else                          gap_q <= '0;
  end

  AST_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_req_o |=> !code_req_o); // R3
  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    framer_busy_i |-> !code_req_o); // R3
  AST_UP_ON_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_det_i) |=> link_up_o); // R4
  AST_GAP_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_up_o |-> (gap_q < GW'(RX_TIMEOUT))); // R5
  AST_LOST_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_lost_o |-> (!link_up_o && $past(link_up_o))); // R6
  AST_LOST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_lost_o |=> !link_lost_o); // R6
  AST_DIS_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!link_up_o && !link_lost_o)); // R8
endmodule

bind link_keepalive_mon kam_checker #(
  .RX_TIMEOUT(RX_TIMEOUT)
) i_kam_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .en_i          (en_i),
  .code_det_i    (code_det_i),
  .framer_busy_i (framer_busy_i),
  .code_req_o    (code_req_o),
  .link_up_o     (link_up_o),
  .link_lost_o   (link_lost_o)
);

// File: tb/test_link_keepalive_mon.sv
`timescale 1ns/1ps
module test_link_keepalive_mon;
  localparam int unsigned TXI = 2048;
  localparam int unsigned RXT = 4096;

  typedef struct packed {
    logic [15:0] gap;
    logic        exp_lost;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{gap: 16'd100,  exp_lost: 1'b0},
    '{gap: 16'd2047, exp_lost: 1'b0},
    '{gap: 16'd4095, exp_lost: 1'b0},
    '{gap: 16'd4096, exp_lost: 1'b0},
    '{gap: 16'd4097, exp_lost: 1'b1},
    '{gap: 16'd3,    exp_lost: 1'b0},
    '{gap: 16'd8000, exp_lost: 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic code = 1'b0;
  logic busy = 1'b0;
  logic req, up, lost;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  link_keepalive_mon #(.TX_INTERVAL(TXI), .RX_TIMEOUT(RXT)) i_link_keepalive_mon (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .code_det_i(code),
    .framer_busy_i(busy), .code_req_o(req), .link_up_o(up), .link_lost_o(lost)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // n falling edges; req must be low before the last and high at it
  task automatic expect_req_at(input int n, input string tag);
    int early = 0;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      if (k < n && req) early++;
    end
    chk(early == 0, tag, "early requests", early, 0);
    chk(req == 1'b1, tag, "request on interval", int'(req), 1);
  endtask

  task automatic code_pulse();
    code = 1'b1;
    @(negedge clk);
    code = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int lost_cnt;
    int hits;
    int at;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk({req, up, lost} == 3'b000, "R1", "outputs in reset", int'({req, up, lost}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(up == 1'b0, "R1", "link down after reset", int'(up), 0);

    // R2 first request after enable
    en = 1'b1;
    expect_req_at(TXI, "R2");
    // R3 pulse width, hold-off under busy, merge
    @(negedge clk);
    chk(req == 1'b0, "R3", "single-cycle request", int'(req), 0);
    busy = 1'b1;
    hits = 0;
    for (int k = 2050; k <= 4196; k++) begin
      @(negedge clk);
      if (req) hits++;
    end
    chk(hits == 0, "R3", "requests while busy", hits, 0);
    busy = 1'b0;
    #1;
    chk(req == 1'b1, "R3", "request on first idle cycle", int'(req), 1);
    @(negedge clk);
    chk(req == 1'b0, "R3", "released request is one cycle", int'(req), 0);
    busy = 1'b1;
    for (int k = 4198; k <= 8292; k++) @(negedge clk);
    busy = 1'b0;
    #1;
    chk(req == 1'b1, "R3", "merged request issued", int'(req), 1);
    expect_req_at(10240 - 8292, "R2");
    chk(up == 1'b0, "R4", "no link without codes", int'(up), 0);

    // R4 bring-up, then R5/R6 gap table
    code_pulse();
    chk(up == 1'b1, "R4", "link up after code", int'(up), 1);
    for (int i = 0; i < NV; i++) begin
      lost_cnt = 0;
      repeat (int'(VEC[i].gap) - 1) begin
        @(negedge clk);
        if (lost) lost_cnt++;
      end
      code_pulse();
      if (lost) lost_cnt++;
      chk(lost_cnt == int'(VEC[i].exp_lost), VEC[i].exp_lost ? "R6" : "R5",
          "loss events for gap", lost_cnt, int'(VEC[i].exp_lost));
      chk(up == 1'b1, "R5", "link up after code", int'(up), 1);
    end

    // R6 exact timeout, R7 interval restart and recovery
    at = 0;
    for (int k = 1; k <= 5000 && at == 0; k++) begin
      @(negedge clk);
      if (lost) at = k;
    end
    chk(at == int'(RXT), "R6", "edges to loss", at, int'(RXT));
    chk(up == 1'b0, "R6", "link down on loss", int'(up), 0);
    @(negedge clk);
    chk(lost == 1'b0, "R6", "loss pulse one cycle", int'(lost), 0);
    expect_req_at(TXI - 1, "R7");
    code_pulse();
    chk(up == 1'b1, "R7", "link recovers on code", int'(up), 1);

    // R8 disable
    en = 1'b0;
    @(negedge clk);
    chk(up == 1'b0, "R8", "disable drops link", int'(up), 0);
    chk(lost == 1'b0, "R8", "no loss event on disable", int'(lost), 0);
    code_pulse();
    chk(up == 1'b0, "R8", "code ignored while disabled", int'(up), 0);
    hits = 0;
    for (int k = 0; k < 3000; k++) begin
      @(negedge clk);
      if (req || lost || up) hits++;
    end
    chk(hits == 0, "R8", "activity while disabled", hits, 0);
    en = 1'b1;
    expect_req_at(TXI, "R8");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule